// File: doc/BRIEF.md
# Calendar Clock Core

This core keeps wall-clock time and a calendar from a 32.768 kHz input clock. A divider turns the input clock into one update per second. Each update moves seconds, minutes, hours, day of week, day of month, month and a two-digit year forward, with every carry. It then checks the new time against three alarm bytes and stores the result.

A host reads and writes fourteen byte registers through a synchronous port with an address, a write strobe and a read strobe. Addresses 0 to 9 hold the time, the date and the alarm. Addresses 0Ah to 0Dh hold control and status. Time values are held either in BCD or in binary, and hours either in 24-hour form or in 12-hour form with a PM bit. A single interrupt line reports alarm matches, a periodic tick and the end of each update, each under its own enable.

Top module: `cal_clock`

## Requirements
- R1: With register A bits 6:4 equal to 3'b010, time advances once every TICKS_PER_SEC input clocks. The first advance lands on the TICKS_PER_SEC-th rising edge after the write that set that field.
- R2: Byte map: 0 second (0–59), 1 minute (0–59), 2 hour, 3 day of week (1–7), 4 day of month, 5 month (1–12), 6 year (0–99). Each field wraps to its lowest value and carries into the next one. April, June, September and November have 30 days; other months except February have 31.
- R3: February has 29 days when the year is divisible by four, and 28 otherwise.
- R4: Register B bit 2 = 1 selects binary and 0 selects BCD. Bit 1 = 1 selects 24-hour mode (0–23). In 12-hour mode the hour runs 12, 1 … 11, and bit 7 of the hour byte set means PM.
- R5: No update happens while register B bit 7 is 1, or while register A bits 6:4 hold any value other than 3'b010.
- R6: Register A bit 7 reads 1 during the UIP_LEAD input clocks just before an update, and reads 0 from the update edge onward.
- R7: A host write to a time register on the same edge as an update stores the written byte. Registers the host does not write that cycle take their updated values.
- R8: Every update sets register C bit 4. Bit 5 is set when the new second, minute and hour equal alarm bytes 7, 8 and 9. An alarm byte whose bits 7:6 are both 1 matches any value.
- R9: When register A bits 3:0 hold a nonzero rate r, register C bit 6 is set once every 2^(r-1) input clocks. A rate of 0 never sets it.
- R10: A read of register C (read strobe with address 0Ch) clears bits 6:4. Bit 7 of C and the irq output are the OR of each flag ANDed with its enable in register B (bit 6 periodic, bit 5 alarm, bit 4 update). Register D reads 80h. After reset every register reads 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz timebase clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 4 | Register byte address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, acts on the rising edge |
| rd_en | input | 1 | Read strobe; with address 0Ch it clears the flags |
| rdata | output | 8 | Read data for addr, combinational |
| irq | output | 1 | Active-high interrupt request |

## Verification
The bench drives the date through rollovers that involve every field at once: end of year, end of a 30-day month, February 28 and 29 in leap and non-leap years, and the noon and midnight crossings in 12-hour mode. A wrong carry chain or a wrong month table shows up there as a stale or skipped date, and a wrong format conversion shows up as 0Ah where 10h is expected. The bench counts clocks to the exact edge where the warning flag rises and the time advances, so an off-by-one divider or warning window is caught. It also lands a host write on the update edge, so a core where the hardware wins loses the written second. Finally it checks that the alarm don't-care code matches, that reading C clears the flags and drops irq, and that the periodic rate and the inhibit conditions behave as specified.

// File: rtl/cal_clock.sv
module cal_clock #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int UIP_LEAD      = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] addr,
  input  logic [7:0] wdata,
  input  logic       wr_en,
  input  logic       rd_en,
  output logic [7:0] rdata,
  output logic       irq
);
  localparam int CW = $clog2(TICKS_PER_SEC);
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);
  localparam logic [CW-1:0] WARN = CW'(TICKS_PER_SEC - UIP_LEAD);

  logic [7:0]    tm [0:9];
  logic [2:0]    dv;
  logic [3:0]    rs;
  logic [7:0]    regb;
  logic          pf, af, uf;
  logic [CW-1:0] cnt;
  logic [14:0]   pcnt;

  function automatic logic [6:0] to_bin(input logic [7:0] v, input logic bin);
    return bin ? v[6:0] : 7'({3'b0, v[7:4]} * 7'd10 + {3'b0, v[3:0]});
  endfunction

  function automatic logic [7:0] from_bin(input logic [6:0] v, input logic bin);
    return bin ? {1'b0, v} : {4'(v / 7'd10), 4'(v % 7'd10)};
  endfunction

  function automatic logic hit(input logic [7:0] v, input logic [7:0] alm);
    return (alm[7:6] == 2'b11) || (alm == v);
  endfunction

  wire dm  = regb[2];
  wire h24 = regb[1];
  wire run = (dv == 3'b010);
  wire upd = run && !regb[7] && (cnt == LAST);
  wire uip = run && !regb[7] && (cnt >= WARN);

  logic [15:0] plen;
  logic [14:0] pmask;
  assign plen  = 16'(1) << rs;
  assign pmask = 15'(plen >> 1) - 15'd1;
  wire ptick = run && (rs != 4'd0) && ((pcnt & pmask) == pmask);

  logic [6:0] s_b, m_b, hraw, h_b, w_b, d_b, mo_b, y_b, mdays;
  logic [6:0] ns, nm, nh, nw, nd, nmo, ny, h12;
  logic       c_s, c_m, c_h, c_d, c_mo;
  logic [7:0] hbyte;
  logic [7:0] nx [0:6];

  always_comb begin
    s_b  = to_bin(tm[0], dm);
    m_b  = to_bin(tm[1], dm);
    hraw = to_bin({1'b0, tm[2][6:0]}, dm);
    h_b  = h24 ? to_bin(tm[2], dm)
               : ((hraw == 7'd12 ? 7'd0 : hraw) + (tm[2][7] ? 7'd12 : 7'd0));
    w_b  = to_bin(tm[3], dm);
    d_b  = to_bin(tm[4], dm);
    mo_b = to_bin(tm[5], dm);
    y_b  = to_bin(tm[6], dm);
    case (mo_b)
      7'd4, 7'd6, 7'd9, 7'd11: mdays = 7'd30;
      7'd2:                    mdays = (y_b[1:0] == 2'b00) ? 7'd29 : 7'd28;
      default:                 mdays = 7'd31;
    endcase
    c_s  = (s_b >= 7'd59);
    c_m  = c_s && (m_b >= 7'd59);
    c_h  = c_m && (h_b >= 7'd23);
    c_d  = c_h && (d_b >= mdays);
    c_mo = c_d && (mo_b >= 7'd12);
    ns   = c_s ? 7'd0 : s_b + 7'd1;
    nm   = c_s ? (c_m ? 7'd0 : m_b + 7'd1) : m_b;
    nh   = c_m ? (c_h ? 7'd0 : h_b + 7'd1) : h_b;
    nw   = c_h ? ((w_b >= 7'd7) ? 7'd1 : w_b + 7'd1) : w_b;
    nd   = c_h ? (c_d ? 7'd1 : d_b + 7'd1) : d_b;
    nmo  = c_d ? (c_mo ? 7'd1 : mo_b + 7'd1) : mo_b;
    ny   = c_mo ? ((y_b >= 7'd99) ? 7'd0 : y_b + 7'd1) : y_b;
    h12  = (nh == 7'd0) ? 7'd12 : ((nh > 7'd12) ? nh - 7'd12 : nh);
    hbyte = from_bin(h12, dm);
    nx[0] = from_bin(ns, dm);
    nx[1] = from_bin(nm, dm);
    nx[2] = h24 ? from_bin(nh, dm) : {(nh >= 7'd12), hbyte[6:0]};
    nx[3] = from_bin(nw, dm);
    nx[4] = from_bin(nd, dm);
    nx[5] = from_bin(nmo, dm);
    nx[6] = from_bin(ny, dm);
  end

  wire alarm_hit = hit(nx[0], tm[7]) && hit(nx[1], tm[8]) && hit(nx[2], tm[9]);
  wire irqf = (pf && regb[6]) || (af && regb[5]) || (uf && regb[4]);
  assign irq = irqf;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 10; i++) tm[i] <= 8'h00;
      dv <= '0; rs <= '0; regb <= '0;
      pf <= 1'b0; af <= 1'b0; uf <= 1'b0;
      cnt <= '0; pcnt <= '0;
    end else begin
      if (!run) begin
        cnt  <= '0;
        pcnt <= '0;
      end else begin
        cnt  <= (cnt == LAST) ? '0 : cnt + 1'b1;
        pcnt <= pcnt + 15'd1;
      end
      if (rd_en && addr == 4'hC) begin
        pf <= 1'b0; af <= 1'b0; uf <= 1'b0;
      end
      if (ptick) pf <= 1'b1;
      if (upd) begin
        for (int i = 0; i < 7; i++) tm[i] <= nx[i];
        uf <= 1'b1;
        if (alarm_hit) af <= 1'b1;
      end
      if (wr_en) begin
        case (addr)
          4'h0, 4'h1, 4'h2, 4'h3, 4'h4,
          4'h5, 4'h6, 4'h7, 4'h8, 4'h9: tm[addr] <= wdata;
          4'hA: {dv, rs} <= wdata[6:0];
          4'hB: regb <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr)
      4'h0, 4'h1, 4'h2, 4'h3, 4'h4,
      4'h5, 4'h6, 4'h7, 4'h8, 4'h9: rdata = tm[addr];
      4'hA:    rdata = {uip, dv, rs};
      4'hB:    rdata = regb;
      4'hC:    rdata = {irqf, pf, af, uf, 4'b0000};
      4'hD:    rdata = 8'h80;
      default: rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/cal_clock_chk.sv
module cal_clock_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       rd_en,
  input logic       irq,
  input logic       set_bit,
  input logic       upd,
  input logic       uip,
  input logic       ptick,
  input logic       uf,
  input logic [3:0] addr,
  input logic [7:0] wdata,
  input logic [7:0] sec
);
  assert_host_write_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'h0) |=> (sec == $past(wdata)));

  assert_set_freezes_time_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (set_bit && !wr_en) |=> $stable(sec));

  assert_uip_drops_after_update_R6: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> !uip);

  assert_update_flag_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> uf);

  assert_read_clears_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 4'hC && !upd && !ptick) |=> !irq);
endmodule

bind cal_clock cal_clock_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .irq(irq),
  .set_bit(regb[7]), .upd(upd), .uip(uip), .ptick(ptick), .uf(uf),
  .addr(addr), .wdata(wdata), .sec(tm[0])
);

// File: tb/sim_cal_clock.sv
module sim_cal_clock;
  localparam int TICKS = 64;
  localparam int LEAD  = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] rdata;
  logic       irq;
  int errors = 0, checks = 0;
  logic [7:0] r;
  logic [119:0] v;

  always #4 clk = ~clk;

  cal_clock #(.TICKS_PER_SEC(TICKS), .UIP_LEAD(LEAD)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata), .irq(irq));

  // {mode, start sec..year, expected sec..year}
  localparam logic [119:0] VEC [8] = '{
    {8'h06, 56'h3B_3B_17_07_1F_0C_63, 56'h00_00_00_01_01_01_00},
    {8'h02, 56'h59_59_23_07_28_02_23, 56'h00_00_00_01_01_03_23},
    {8'h02, 56'h59_59_23_03_28_02_24, 56'h00_00_00_04_29_02_24},
    {8'h00, 56'h59_59_11_01_15_06_10, 56'h00_00_92_01_15_06_10},
    {8'h00, 56'h59_59_91_02_30_04_05, 56'h00_00_12_03_01_05_05},
    {8'h04, 56'h3B_3B_0C_05_0A_03_07, 56'h00_00_01_05_0A_03_07},
    {8'h06, 56'h3B_3B_17_06_1D_02_04, 56'h00_00_00_07_01_03_04},
    {8'h02, 56'h09_00_00_01_01_01_00, 56'h10_00_00_01_01_01_00}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%02h exp=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic peek(input logic [3:0] a, output logic [7:0] d);
    addr = a; #1 d = rdata;
  endtask

  task automatic rdc(output logic [7:0] d);
    @(negedge clk); addr = 4'hC; rd_en = 1'b1; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic wait_edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    peek(4'hA, r); chk("R10 reset A", r, 8'h00);
    peek(4'hB, r); chk("R10 reset B", r, 8'h00);
    peek(4'hC, r); chk("R10 reset C", r, 8'h00);
    peek(4'h0, r); chk("R10 reset sec", r, 8'h00);
    peek(4'hD, r); chk("R10 reg D", r, 8'h80);
    chk("R10 reset irq", {7'b0, irq}, 8'h00);

    // R2 R3 R4 vector walk
    for (int i = 0; i < 8; i++) begin
      v = VEC[i];
      wr(4'hA, 8'h00);
      wr(4'hB, 8'h80 | v[119:112]);
      for (int k = 0; k < 7; k++) wr(4'(k), v[111-8*k -: 8]);
      wr(4'hB, v[119:112]);
      wr(4'hA, 8'h20);
      wait_edges(TICKS);
      for (int k = 0; k < 7; k++) begin
        peek(4'(k), r);
        chk($sformatf("R2/R3/R4 vec%0d byte%0d", i, k), r, v[55-8*k -: 8]);
      end
    end

    // R5 set bit inhibits
    wr(4'hA, 8'h00); wr(4'hB, 8'h82); wr(4'h0, 8'h09); wr(4'hA, 8'h20);
    wait_edges(TICKS + 4);
    peek(4'h0, r); chk("R5 set inhibit", r, 8'h09);
    wr(4'hB, 8'h02); wr(4'hA, 8'h30);
    wait_edges(TICKS + 4);
    peek(4'h0, r); chk("R5 bad divider", r, 8'h09);

    // R1 R6 timing
    wr(4'hA, 8'h00); wr(4'h0, 8'h00); wr(4'hA, 8'h20);
    wait_edges(TICKS - LEAD - 1);
    peek(4'hA, r); chk("R6 uip before window", r, 8'h20);
    wait_edges(1);
    peek(4'hA, r); chk("R6 uip rises", r, 8'hA0);
    wait_edges(LEAD - 1);
    peek(4'hA, r); chk("R6 uip held", r, 8'hA0);
    peek(4'h0, r); chk("R1 no early advance", r, 8'h00);
    wait_edges(1);
    peek(4'hA, r); chk("R6 uip cleared", r, 8'h20);
    peek(4'h0, r); chk("R1 advance on edge", r, 8'h01);

    // R7 collision
    wr(4'hA, 8'h00); wr(4'h0, 8'h59); wr(4'h1, 8'h00); wr(4'hA, 8'h20);
    wait_edges(TICKS - 1);
    addr = 4'h0; wdata = 8'h40; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    peek(4'h0, r); chk("R7 host wins", r, 8'h40);
    peek(4'h1, r); chk("R7 other field updates", r, 8'h01);

    // R8 R10 alarm and update flags
    wr(4'hA, 8'h00); wr(4'hB, 8'h32); rdc(r);
    wr(4'h0, 8'h04); wr(4'h7, 8'h05); wr(4'h8, 8'hC0); wr(4'h9, 8'hC0);
    wr(4'hA, 8'h20);
    wait_edges(TICKS);
    chk("R10 irq on alarm", {7'b0, irq}, 8'h01);
    rdc(r); chk("R8 alarm match flags", r, 8'hB0);
    peek(4'hC, r); chk("R10 read clears C", r, 8'h00);
    chk("R10 irq drops", {7'b0, irq}, 8'h00);
    wr(4'hA, 8'h00); wr(4'h0, 8'h10); wr(4'hA, 8'h20);
    wait_edges(TICKS);
    rdc(r); chk("R8 alarm mismatch", r, 8'h90);

    // R9 periodic
    wr(4'hB, 8'h42); wr(4'hA, 8'h00); rdc(r);
    wr(4'hA, 8'h23);
    wait_edges(3);
    chk("R9 no tick yet", {7'b0, irq}, 8'h00);
    wait_edges(1);
    chk("R9 tick after period", {7'b0, irq}, 8'h01);
    rdc(r); chk("R9 periodic flag", r, 8'hC0);
    wr(4'hA, 8'h20); rdc(r);
    wait_edges(20);
    peek(4'hC, r); chk("R9 rate zero silent", r & 8'h40, 8'h00);
    chk("R9 rate zero irq", {7'b0, irq}, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule